// File: doc/BRIEF.md
# Byte-Framed SPI Register Access Slave

This block is an SPI slave that lets an external host read and write a 32-location byte register space inside the chip. Each chip-select frame opens with a command byte. The command byte selects a starting location, chooses between read and write, and can request an acknowledge strobe. Any number of data bytes may follow in the same frame. The low five locations are FIFO ports. A burst to one of them keeps hitting the same location, so each data byte pushes or pops one FIFO entry. Every other location steps forward by one on each data byte, and the pointer wraps from 31 to 0.

Inside the chip the block drives a simple bus. It has one address, one write-data byte, a register write strobe, a FIFO push strobe, a FIFO pop strobe and a one-cycle acknowledge strobe. It reads back one combinational read-data byte. For a FIFO location, the read-data byte must show the head entry without removing it. The block works in full-duplex SPI mode 0, MSB first. SCK, chip select and MOSI are brought into the system clock domain through two-flop synchronizers. For this reason each SCK half period must last at least 6 system clocks.

Top module: `spi_regslave`

## Requirements
- R1: The command byte uses these fields: bits 7:3 give the start location, bit 1 gives the direction (1 write, 0 read) and bit 0 is the acknowledge flag. Bit 2 has no effect.
- R2: A frame made of a write command and one data byte produces exactly one write strobe. The strobe carries that location and that byte: `reg_we` for locations 5 to 31, `fifo_push` for locations 0 to 4.
- R3: In a read frame, the value at the start location appears on MISO MSB first during the second byte. MISO changes after falling SCK edges and is valid at each rising edge.
- R4: A frame holding only a command byte with the acknowledge flag set raises `ack_pulse` for exactly one cycle. It produces no write, push or pop strobe.
- R5: When the acknowledge flag is set on a read or write frame, the access still takes place and `ack_pulse` fires once as well.
- R6: In a burst to locations 5 to 31, the location advances by one after each data byte and wraps from 31 to 0. Once the pointer reaches 0 to 4 it stops advancing.
- R7: A 4-byte read burst starting at location 11 returns the contents of locations 11, 12, 13 and 14 in that order.
- R8: A write burst to a FIFO location (0 to 4) gives one `fifo_push` per data byte, always at the same location, and no `reg_we`.
- R9: A read burst from a FIFO location gives exactly one `fifo_pop` per data byte clocked out. Bytes come out in push order, and no pop is made for data the host never clocks.
- R10: If chip select is released partway through a byte, the frame is dropped. No strobe is produced for the partial byte, and the next frame decodes a fresh command.
- R11: After reset and while chip select is idle, all strobes are low and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host-to-slave serial data |
| spi_miso | output | 1 | Slave-to-host serial data |
| bus_addr | output | 5 | Current register or FIFO location |
| bus_wdata | output | 8 | Byte written with `reg_we` or `fifo_push` |
| bus_rdata | input | 8 | Value at `bus_addr` (FIFO head for locations 0 to 4) |
| reg_we | output | 1 | One-cycle write strobe for locations 5 to 31 |
| fifo_push | output | 1 | One-cycle push strobe for locations 0 to 4 |
| fifo_pop | output | 1 | One-cycle pop strobe for locations 0 to 4 |
| ack_pulse | output | 1 | One-cycle acknowledge strobe |

## Verification
The bench writes and reads back every ordinary location, so a misplaced address field, a direction bit read from the wrong position or an off-by-one in MISO timing would show up as wrong data at some location. FIFO bursts to all five ports check that the address stays put and that the pop count equals the number of bytes. A block that prefetched and popped one byte ahead would come up one pop over and would lose that entry. Other cases cover the wrap from 31 into the FIFO range, acknowledge-only frames in both directions, and a frame aborted halfway through a data byte. A design that committed partial bytes would overwrite the location, and one that kept its bit count across frames would misdecode the next command.

// File: rtl/spi_regslave_pkg.sv
// Shared constants and types for the SPI register access slave.
// Assumes an 8-bit command byte with the location field in the top bits.
package spi_regslave_pkg;
    localparam int CMD_WR_BIT  = 1;
    localparam int CMD_ACK_BIT = 0;

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_t;
endpackage

// File: rtl/spi_regslave_sync.sv
// Two-flop synchronizer bank for asynchronous SPI pins.
// Each bit gets its own reset value so chip select can idle high.
module spi_regslave_sync #(
    parameter int             N       = 3,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [1:0] stage;
        // Shift the pin value through two flops.
        always_ff @(posedge clk) begin
            if (!rst_n) stage <= {2{RST_VAL[g]}};
            else        stage <= {stage[0], d[g]};
        end
        assign q[g] = stage[1];
    end
endmodule

// File: rtl/spi_regslave_shifter.sv
// Bit-level engine: finds SCK edges, assembles received bytes and shifts
// out transmit bytes in SPI mode 0, MSB first.
// Assumes synchronized inputs and at least 6 clocks per SCK half period,
// so that a load always lands between the last rising edge of a byte
// and the falling edge that follows it.
module spi_regslave_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sck_s,
    input  logic         cs_act,
    input  logic         mosi_s,
    input  logic         load,
    input  logic [W-1:0] load_data,
    output logic         byte_done,
    output logic [W-1:0] rx_byte,
    output logic         first_bit,
    output logic         miso
);
    localparam int            CW   = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          sck_q;
    logic [CW-1:0] bitcnt;
    logic [W-2:0]  rx_sh;
    logic [W-1:0]  tx_sh;
    logic          rise, fall;

    assign rise      = cs_act & sck_s & ~sck_q;
    assign fall      = cs_act & ~sck_s & sck_q;
    assign first_bit = rise && (bitcnt == '0);
    assign miso      = cs_act & tx_sh[W-1];

    // Receive side: count bits and emit a byte pulse on every eighth rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q     <= 1'b0;
            bitcnt    <= '0;
            rx_sh     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else begin
            sck_q     <= sck_s;
            byte_done <= 1'b0;
            if (!cs_act) begin
                bitcnt <= '0;
            end else if (rise) begin
                bitcnt <= (bitcnt == LAST) ? '0 : bitcnt + CW'(1);
                rx_sh  <= {rx_sh[W-3:0], mosi_s};
                if (bitcnt == LAST) begin
                    rx_byte   <= {rx_sh, mosi_s};
                    byte_done <= 1'b1;
                end
            end
        end
    end

    // Transmit side: load at byte boundaries, shift on falling edges inside a byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                    tx_sh <= '0;
        else if (!cs_act)              tx_sh <= '0;
        else if (load)                 tx_sh <= load_data;
        else if (fall && bitcnt != '0) tx_sh <= {tx_sh[W-2:0], 1'b0};
    end

    a_r3_load_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (bitcnt == '0));
    a_r10_byte_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);
endmodule

// File: rtl/spi_regslave_ctrl.sv
// Frame controller: decodes the command byte, keeps the location pointer,
// and produces the bus strobes. FIFO locations hold the pointer still.
// A FIFO pop is issued when the host clocks the first bit of a data byte,
// so a trailing peek at the end of a burst never removes an entry.
module spi_regslave_ctrl
    import spi_regslave_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int FIFO_N = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              first_bit,
    output logic              load,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              reg_we,
    output logic              fifo_push,
    output logic              fifo_pop,
    output logic              ack_pulse
);
    localparam logic [ADDR_W-1:0] FIFO_LIM = ADDR_W'(FIFO_N);

    phase_t            phase;
    logic [ADDR_W-1:0] ptr;
    logic              is_wr;
    logic              in_fifo;
    logic              wr_stb;
    logic [ADDR_W-1:0] cmd_addr;

    assign cmd_addr = rx_byte[DATA_W-1 -: ADDR_W];
    assign in_fifo  = ptr < FIFO_LIM;

    // Phase, pointer and read-load sequencing across one chip-select frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_CMD;
            ptr   <= '0;
            is_wr <= 1'b0;
            load  <= 1'b0;
        end else if (!cs_act) begin
            phase <= PH_CMD;
            load  <= 1'b0;
        end else begin
            load <= 1'b0;
            if (byte_done) begin
                if (phase == PH_CMD) begin
                    phase <= PH_DATA;
                    ptr   <= cmd_addr;
                    is_wr <= rx_byte[CMD_WR_BIT];
                    load  <= ~rx_byte[CMD_WR_BIT];
                end else begin
                    if (!in_fifo) ptr <= ptr + ADDR_W'(1);
                    load <= ~is_wr;
                end
            end
        end
    end

    assign wr_stb    = byte_done && (phase == PH_DATA) && is_wr;
    assign reg_we    = wr_stb && !in_fifo;
    assign fifo_push = wr_stb && in_fifo;
    assign fifo_pop  = first_bit && (phase == PH_DATA) && !is_wr && in_fifo;
    assign ack_pulse = byte_done && (phase == PH_CMD) && rx_byte[CMD_ACK_BIT];
    assign bus_addr  = ptr;
    assign bus_wdata = rx_byte;

    a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we, fifo_push, fifo_pop, ack_pulse}));
    a_r4_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pulse |=> !ack_pulse);
    a_r8_fifo_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && in_fifo) |=> $stable(ptr));
    a_r6_reg_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && phase == PH_DATA && !in_fifo && cs_act) |=> (ptr == $past(ptr) + ADDR_W'(1)));
endmodule

// File: rtl/spi_regslave.sv
// Top level of the SPI register access slave: synchronizes the SPI pins,
// runs the bit engine and the frame controller, and exposes the register
// bus and FIFO strobes. Register and FIFO storage sit outside this block.
module spi_regslave #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int FIFO_N = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              reg_we,
    output logic              fifo_push,
    output logic              fifo_pop,
    output logic              ack_pulse
);
    logic [2:0]        pins_s;
    logic              byte_done, first_bit, load;
    logic [DATA_W-1:0] rx_byte;

    spi_regslave_sync #(.N(3), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_sck, spi_cs_n, spi_mosi}),
        .q     (pins_s)
    );

    spi_regslave_shifter #(.W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (pins_s[2]),
        .cs_act    (~pins_s[1]),
        .mosi_s    (pins_s[0]),
        .load      (load),
        .load_data (bus_rdata),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .first_bit (first_bit),
        .miso      (spi_miso)
    );

    spi_regslave_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIFO_N(FIFO_N)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (~pins_s[1]),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .first_bit (first_bit),
        .load      (load),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .reg_we    (reg_we),
        .fifo_push (fifo_push),
        .fifo_pop  (fifo_pop),
        .ack_pulse (ack_pulse)
    );

    a_r11_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_s[1] && $past(pins_s[1])) |-> !spi_miso);
endmodule

// File: tb/spi_regslave_test.sv
// Self-checking bench: models the register file and five FIFOs behind the
// bus and drives SPI frames as a mode-0 host.
module spi_regslave_test;
    localparam int HALF = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, sck, cs_n, mosi;
    logic       miso, reg_we, fifo_push, fifo_pop, ack_pulse;
    logic [4:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;

    spi_regslave uut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .reg_we(reg_we), .fifo_push(fifo_push), .fifo_pop(fifo_pop), .ack_pulse(ack_pulse)
    );

    // Storage model behind the bus.
    logic [7:0] regs [32];
    logic [7:0] fmem [5][16];
    logic [3:0] head [5];
    logic [3:0] tail [5];
    int we_cnt, push_cnt, pop_cnt, ack_cnt;
    int last_addr, last_data, last_paddr, last_pdata;

    assign bus_rdata = (bus_addr < 5'd5) ? fmem[bus_addr][head[bus_addr]] : regs[bus_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) regs[i] <= 8'(i * 7);
            for (int f = 0; f < 5; f++) begin head[f] <= '0; tail[f] <= '0; end
            we_cnt <= 0; push_cnt <= 0; pop_cnt <= 0; ack_cnt <= 0;
        end else begin
            if (reg_we) begin
                regs[bus_addr] <= bus_wdata;
                we_cnt <= we_cnt + 1; last_addr <= bus_addr; last_data <= bus_wdata;
            end
            if (fifo_push) begin
                fmem[bus_addr][tail[bus_addr]] <= bus_wdata;
                tail[bus_addr] <= tail[bus_addr] + 4'd1;
                push_cnt <= push_cnt + 1; last_paddr <= bus_addr; last_pdata <= bus_wdata;
            end
            if (fifo_pop) begin
                head[bus_addr] <= head[bus_addr] + 4'd1;
                pop_cnt <= pop_cnt + 1;
            end
            if (ack_pulse) ack_cnt <= ack_cnt + 1;
        end
    end

    int checks = 0, errors = 0;
    logic [7:0] txb [16];
    logic [7:0] rxb [16];
    logic [7:0] junk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk(input int addr, input bit wr, input bit ack);
        return {5'(addr), 1'b0, wr, ack};
    endfunction

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 29 + 3);
    endfunction

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic frame(input logic [7:0] cmd, input int n);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        xfer(cmd, junk);
        for (int i = 0; i < n; i++) xfer(txb[i], rxb[i]);
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_up();
    end

    initial begin
        int w0, p0, q0, a0;
        rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; mosi = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R11: idle after reset
        check(!miso && !reg_we && !fifo_push && !fifo_pop && !ack_pulse, "R11",
              {miso, reg_we, fifo_push, fifo_pop, ack_pulse}, 0);

        // R2 / R3: single write and read at every ordinary location
        for (int a = 5; a < 32; a++) begin
            w0 = we_cnt;
            txb[0] = pat(a);
            frame(mk(a, 1, 0), 1);
            check(we_cnt == w0 + 1 && last_addr == a && last_data == pat(a), "R2",
                  last_data, pat(a));
            frame(mk(a, 0, 0), 1);
            check(rxb[0] == pat(a), "R3", rxb[0], pat(a));
        end

        // R1: bit 2 set in a write command changes nothing
        w0 = we_cnt; txb[0] = 8'h5A;
        frame(mk(20, 1, 0) | 8'h04, 1);
        check(we_cnt == w0 + 1 && last_addr == 20 && last_data == 8'h5A, "R1", last_data, 8'h5A);
        frame(mk(20, 0, 0) | 8'h04, 1);
        check(rxb[0] == 8'h5A, "R1", rxb[0], 8'h5A);

        // R4: acknowledge-only frames, read and write direction
        w0 = we_cnt; p0 = push_cnt; q0 = pop_cnt; a0 = ack_cnt;
        frame(mk(0, 0, 1), 0);
        frame(mk(9, 1, 1), 0);
        check(ack_cnt == a0 + 2, "R4", ack_cnt - a0, 2);
        check(we_cnt == w0 && push_cnt == p0 && pop_cnt == q0, "R4",
              we_cnt - w0 + push_cnt - p0 + pop_cnt - q0, 0);

        // R5: acknowledge flag with a write and with a read
        w0 = we_cnt; a0 = ack_cnt; txb[0] = 8'hC3;
        frame(mk(9, 1, 1), 1);
        check(we_cnt == w0 + 1 && ack_cnt == a0 + 1 && last_data == 8'hC3, "R5", last_data, 8'hC3);
        frame(mk(9, 0, 1), 1);
        check(ack_cnt == a0 + 2 && rxb[0] == 8'hC3, "R5", rxb[0], 8'hC3);

        // R6 / R7: write burst 11..14, then read it back as a burst
        w0 = we_cnt;
        for (int i = 0; i < 4; i++) txb[i] = 8'(8'hA0 + i);
        frame(mk(11, 1, 0), 4);
        check(we_cnt == w0 + 4 && last_addr == 14, "R6", last_addr, 14);
        frame(mk(11, 0, 0), 4);
        for (int i = 0; i < 4; i++) check(rxb[i] == 8'(8'hA0 + i), "R7", rxb[i], 8'hA0 + i);

        // R8 / R9: bursts to every FIFO location
        for (int f = 0; f < 5; f++) begin
            w0 = we_cnt; p0 = push_cnt; q0 = pop_cnt;
            for (int i = 0; i < 3; i++) txb[i] = 8'(f * 16 + i + 1);
            frame(mk(f, 1, 0), 3);
            check(push_cnt == p0 + 3 && we_cnt == w0 && last_paddr == f, "R8", push_cnt - p0, 3);
            frame(mk(f, 0, 0), 3);
            check(pop_cnt == q0 + 3, "R9", pop_cnt - q0, 3);
            for (int i = 0; i < 3; i++) check(rxb[i] == 8'(f * 16 + i + 1), "R9", rxb[i], f * 16 + i + 1);
        end

        // R10: release chip select halfway through a data byte
        w0 = we_cnt;
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        xfer(mk(25, 1, 0), junk);
        for (int i = 0; i < 4; i++) begin
            mosi = 1'b1; repeat (HALF) @(negedge clk);
            sck = 1'b1;  repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
        check(we_cnt == w0, "R10", we_cnt - w0, 0);
        frame(mk(25, 0, 0), 1);
        check(rxb[0] == pat(25), "R10", rxb[0], pat(25));

        // R6: wrap from 31 to 0, then stays on FIFO 0
        w0 = we_cnt; p0 = push_cnt;
        txb[0] = 8'h11; txb[1] = 8'h22; txb[2] = 8'h33; txb[3] = 8'h44;
        frame(mk(30, 1, 0), 4);
        check(we_cnt == w0 + 2 && last_addr == 31, "R6", last_addr, 31);
        check(push_cnt == p0 + 2 && last_paddr == 0 && last_pdata == 8'h44, "R6", last_pdata, 8'h44);
        frame(mk(30, 0, 0), 2);
        check(rxb[0] == 8'h11 && rxb[1] == 8'h22, "R6", {rxb[0], rxb[1]}, 16'h1122);

        finish_up();
    end
endmodule